// File: doc/BRIEF.md
# UART Interrupt Priority Resolver

This block merges the four interrupt causes of a 16550-style serial port into one interrupt request line and the code that software reads from the interrupt identification register. The four causes are receiver line errors, received data, an empty transmit holding register and a modem line change. It also holds the interrupt enable register. A write to that register keeps only four bits. The block also holds the one piece of state that the transmit-empty cause needs: a pending flag.

The host side writes the enable register and strobes a read of the identification register. The line status byte, the transmit-empty level, the modem delta nibble and the upper identification bits come in from the neighbouring logic. The upper identification bits are, for example, the FIFO-enabled indicators. The resolved request and the full identification byte leave through registers, one clock after the inputs they depend on. Reset is synchronous and active high.

Top module: `uart_irq_resolver`

## Requirements
- R1: A write to the enable register stores only bits [3:0] of the write data. Bits [7:4] are discarded. The stored value appears on `ier_o` after the write edge.
- R2: While the stored enable value is zero, `irq_o` is low in the following cycle, whatever sources are active.
- R3: Line error cause. It is taken when enable bit 2 is set and any of line status bits [4:1] is set. It has the highest priority and reports code 0x6.
- R4: Received data cause. It is taken when enable bit 0 is set and line status bit 0 is set. It comes second and reports code 0x4.
- R5: Transmit-empty cause. It is taken when enable bit 1 is set and the pending flag is set. It comes third and reports code 0x2.
- R6: Modem cause. It is taken when enable bit 3 is set and any modem delta bit [3:0] is set. It comes last and reports code 0x0.
- R7: When no cause qualifies, the low nibble of `iir_o` is 0x1 and `irq_o` is low. Otherwise `irq_o` is high.
- R8: `iir_o[7:4]` repeats the `iir_hi_i` value sampled at the previous edge. Only `iir_o[3:0]` carries the resolved code.
- R9: `irq_o` and `iir_o` are registered. They reflect the enable value, pending flag and inputs present one edge earlier. After reset, `irq_o`=0, `iir_o`=0x01 and `ier_o`=0.
- R10: The pending flag is set by an enable write that has bit 1 set while `thr_empty_i` is high.
- R11: The pending flag is cleared by an identification read while `iir_o[3:0]` shows 0x2. A read that shows any other code leaves it set. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ier_we_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 8 | Enable register write data |
| lsr_i | input | 8 | Line status byte; bit 0 data ready, bits 4:1 errors |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| msr_delta_i | input | 4 | Modem line change bits |
| iir_rd_i | input | 1 | Identification register read strobe |
| iir_hi_i | input | 4 | Upper identification bits from other logic |
| ier_o | output | 4 | Stored enable value |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification byte |

## Verification
Several relations are checked by assertions on every cycle: that `irq_o` agrees with the reported code, that a zero enable value silences the request, that the line error and received data causes win when they qualify, that the upper bits pass through, and how the pending flag reacts to set and clear. The bench scenarios are what show the full priority ladder. They drop causes one by one, mask causes through the enable bits, and show that a read reporting received data leaves a transmit-empty cause waiting until it surfaces and is read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_MODEM  = 4'h0,
    IID_NONE   = 4'h1,
    IID_THRE   = 4'h2,
    IID_RXDATA = 4'h4,
    IID_LINE   = 4'h6
  } iid_code_e;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W     = 4;
  localparam int CODE_W   = 4;
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int W_IN = 8,
  parameter int W_EN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_i,
  input  logic [W_IN-1:0] wdata_i,
  output logic [W_EN-1:0] en_q
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[W_IN-1:W_EN];

  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (we_i) en_q <= wdata_i[W_EN-1:0];
  end

  // R1: only the low bits survive a write
  p_mask_r1: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (en_q == $past(wdata_i[W_EN-1:0])));
endmodule

// File: rtl/uirq_thre_flag.sv
module uirq_thre_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);
  always_ff @(posedge clk) begin
    if (rst)        pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pend_q);
  p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pend_q);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uart_irq_pkg::*;
#(
  parameter int          LSR_W     = 8,
  parameter int          MSR_W     = 4,
  parameter logic [7:0]  LINE_MASK = 8'h1E
) (
  input  logic [EN_W-1:0]  en_i,
  input  logic [LSR_W-1:0] lsr_i,
  input  logic             pend_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  output iid_code_e        code_o,
  output logic             req_o
);
  localparam int NSRC = 4;

  // qualified causes, index 0 = highest priority
  logic [NSRC-1:0] hit;
  iid_code_e       tab [NSRC];

  assign hit[0] = en_i[EN_LINE]  && |(lsr_i & LINE_MASK[LSR_W-1:0]);
  assign hit[1] = en_i[EN_RX]    && lsr_i[0];
  assign hit[2] = en_i[EN_TX]    && pend_i;
  assign hit[3] = en_i[EN_MODEM] && |msr_delta_i;

  assign tab[0] = IID_LINE;
  assign tab[1] = IID_RXDATA;
  assign tab[2] = IID_THRE;
  assign tab[3] = IID_MODEM;

  always_comb begin
    code_o = IID_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (hit[i]) code_o = tab[i];
    end
  end

  // global gate: a zero enable register silences the request
  assign req_o = (|en_i) && (|hit);
endmodule

// File: rtl/uirq_iir_reg.sv
module uirq_iir_reg
  import uart_irq_pkg::*;
#(
  parameter int HI_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  iid_code_e                code_i,
  input  logic                     req_i,
  input  logic [HI_W-1:0]          hi_i,
  output logic                     irq_q,
  output logic [HI_W+CODE_W-1:0]   iir_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      iir_q <= {{HI_W{1'b0}}, IID_NONE};
    end else begin
      irq_q <= req_i;
      iir_q <= {hi_i, (req_i ? code_i : IID_NONE)};
    end
  end
endmodule

// File: rtl/uart_irq_resolver.sv
module uart_irq_resolver
  import uart_irq_pkg::*;
#(
  parameter int          WD_W      = 8,
  parameter int          LSR_W     = 8,
  parameter int          MSR_W     = 4,
  parameter int          HI_W      = 4,
  parameter logic [7:0]  LINE_MASK = 8'h1E
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ier_we_i,
  input  logic [WD_W-1:0]        ier_wdata_i,
  input  logic [LSR_W-1:0]       lsr_i,
  input  logic                   thr_empty_i,
  input  logic [MSR_W-1:0]       msr_delta_i,
  input  logic                   iir_rd_i,
  input  logic [HI_W-1:0]        iir_hi_i,
  output logic [EN_W-1:0]        ier_o,
  output logic                   irq_o,
  output logic [HI_W+CODE_W-1:0] iir_o
);
  logic [EN_W-1:0] en_q;
  logic            pend_q;
  logic            pend_set;
  logic            pend_clr;
  iid_code_e       code;
  logic            req;

  uirq_enable_reg #(.W_IN(WD_W), .W_EN(EN_W)) u_en (
    .clk(clk), .rst(rst), .we_i(ier_we_i), .wdata_i(ier_wdata_i), .en_q(en_q)
  );

  assign pend_set = ier_we_i && ier_wdata_i[EN_TX] && thr_empty_i;
  assign pend_clr = iir_rd_i && (iir_o[CODE_W-1:0] == IID_THRE);

  uirq_thre_flag u_thre (
    .clk(clk), .rst(rst), .set_i(pend_set), .clr_i(pend_clr), .pend_q(pend_q)
  );

  uirq_prio #(.LSR_W(LSR_W), .MSR_W(MSR_W), .LINE_MASK(LINE_MASK)) u_prio (
    .en_i(en_q), .lsr_i(lsr_i), .pend_i(pend_q), .msr_delta_i(msr_delta_i),
    .code_o(code), .req_o(req)
  );

  uirq_iir_reg #(.HI_W(HI_W)) u_iir (
    .clk(clk), .rst(rst), .code_i(code), .req_i(req), .hi_i(iir_hi_i),
    .irq_q(irq_o), .iir_q(iir_o)
  );

  assign ier_o = en_q;

  p_zero_en_r2: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_o);
  p_line_first_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q[EN_LINE] && |(lsr_i & LINE_MASK[LSR_W-1:0])) |=>
      (iir_o[CODE_W-1:0] == IID_LINE));
  p_rx_second_r4: assert property (@(posedge clk) disable iff (rst)
    (en_q[EN_RX] && lsr_i[0] && !(en_q[EN_LINE] && |(lsr_i & LINE_MASK[LSR_W-1:0])))
      |=> (iir_o[CODE_W-1:0] == IID_RXDATA));
  p_irq_code_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (iir_o[CODE_W-1:0] != IID_NONE));
  p_hi_pass_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (iir_o[HI_W+CODE_W-1:CODE_W] == $past(iir_hi_i)));
endmodule

// File: tb/sim_uart_irq_resolver.sv
`timescale 1ns/1ps
module sim_uart_irq_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ier_we = 1'b0;
  logic [7:0] ier_wd = '0;
  logic [7:0] lsr = '0;
  logic       thr = 1'b0;
  logic [3:0] msr = '0;
  logic       rd = 1'b0;
  logic [3:0] hi = '0;
  logic [3:0] ier_o;
  logic       irq_o;
  logic [7:0] iir_o;

  always #2.5 clk = ~clk;

  uart_irq_resolver u0 (
    .clk(clk), .rst(rst), .ier_we_i(ier_we), .ier_wdata_i(ier_wd),
    .lsr_i(lsr), .thr_empty_i(thr), .msr_delta_i(msr), .iir_rd_i(rd),
    .iir_hi_i(hi), .ier_o(ier_o), .irq_o(irq_o), .iir_o(iir_o)
  );

  typedef struct {
    logic       irq;
    logic [7:0] iir;
    logic [3:0] ier;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic [3:0] m_ier = '0;
  logic       m_pend = 1'b0;
  logic [3:0] m_shown = 4'h1;

  function automatic logic [3:0] ref_code(input logic [3:0] en, input logic [7:0] l,
                                          input logic p, input logic [3:0] m);
    if (en[2] && (l[4:1] != 0)) return 4'h6;
    if (en[0] && l[0])          return 4'h4;
    if (en[1] && p)             return 4'h2;
    if (en[3] && (m != 0))      return 4'h0;
    return 4'h1;
  endfunction

  task automatic step(input logic we, input logic [7:0] wd, input logic [7:0] l,
                      input logic t, input logic [3:0] m, input logic r,
                      input logic [3:0] h, input string tag);
    exp_t e;
    logic [3:0] c;
    @(negedge clk);
    ier_we = we; ier_wd = wd; lsr = l; thr = t; msr = m; rd = r; hi = h;
    c = ref_code(m_ier, l, m_pend, m);
    e.irq = (m_ier != 0) && (c != 4'h1);
    e.iir = {h, c};
    e.ier = we ? wd[3:0] : m_ier;
    e.tag = tag;
    q.push_back(e);
    if (we && wd[1] && t)            m_pend = 1'b1;
    else if (r && (m_shown == 4'h2)) m_pend = 1'b0;
    m_ier   = e.ier;
    m_shown = c;
  endtask

  // monitor: compares each pushed item after its edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irq_o !== e.irq || iir_o !== e.iir || ier_o !== e.ier) begin
        errors++;
        $display("FAIL %s: irq=%0b iir=%02h ier=%01h expected irq=%0b iir=%02h ier=%01h",
                 e.tag, irq_o, iir_o, ier_o, e.irq, e.iir, e.ier);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (irq_o !== 1'b0 || iir_o !== 8'h01 || ier_o !== 4'h0) begin
      errors++;
      $display("FAIL R9 reset: irq=%0b iir=%02h ier=%01h expected 0 01 0", irq_o, iir_o, ier_o);
    end
    rst = 1'b0;
    // R1: upper write bits dropped; thr low so no pending (R10)
    step(1, 8'hFF, 8'h00, 0, 4'h0, 0, 4'h0, "R1");
    step(0, 8'h00, 8'h00, 0, 4'h0, 0, 4'h0, "R7 none");
    // R2: zero enable with everything active
    step(1, 8'hF0, 8'h1F, 1, 4'hF, 0, 4'h0, "R2");
    step(0, 8'h00, 8'h1F, 1, 4'hF, 0, 4'h0, "R2");
    step(0, 8'h00, 8'h1F, 1, 4'hF, 0, 4'hC, "R2 R8");
    // enable all, pending set by write with thr empty (R10)
    step(1, 8'h0F, 8'h1F, 1, 4'hF, 0, 4'hC, "R10");
    step(0, 8'h00, 8'h1F, 1, 4'hF, 0, 4'hC, "R3");
    step(0, 8'h00, 8'h11, 0, 4'hF, 0, 4'h5, "R3 break");
    step(0, 8'h00, 8'h01, 0, 4'hF, 0, 4'hA, "R4 R8");
    // read showing 0x4 must not clear pending
    step(0, 8'h00, 8'h01, 0, 4'hF, 1, 4'hA, "R11 keep");
    step(0, 8'h00, 8'h00, 0, 4'hF, 0, 4'h3, "R5");
    step(0, 8'h00, 8'h00, 0, 4'hF, 0, 4'h3, "R5");
    // read showing 0x2 clears pending
    step(0, 8'h00, 8'h00, 0, 4'hF, 1, 4'h3, "R11 clear");
    step(0, 8'h00, 8'h00, 0, 4'hF, 0, 4'h3, "R6");
    step(0, 8'h00, 8'h00, 0, 4'h2, 0, 4'h3, "R6");
    step(0, 8'h00, 8'h00, 0, 4'h0, 0, 4'h3, "R7 none");
    // masking: only modem enabled, line/data present
    step(1, 8'h08, 8'h1F, 1, 4'h0, 0, 4'h0, "R7 mask");
    step(0, 8'h00, 8'h1F, 1, 4'h0, 0, 4'h0, "R7 mask");
    step(0, 8'h00, 8'h1F, 1, 4'h4, 0, 4'hF, "R6 alone");
    // write with tx enable while thr not empty: no pending
    step(1, 8'h02, 8'h00, 0, 4'h0, 0, 4'h0, "R10 thr busy");
    step(0, 8'h00, 8'h00, 0, 4'h0, 0, 4'h0, "R10 thr busy");
    // set and clear in the same cycle: set wins
    step(1, 8'h02, 8'h00, 1, 4'h0, 0, 4'h0, "R10");
    step(0, 8'h00, 8'h00, 0, 4'h0, 0, 4'h0, "R5");
    step(1, 8'h02, 8'h00, 1, 4'h0, 1, 4'h0, "R11 set wins");
    step(0, 8'h00, 8'h00, 0, 4'h0, 0, 4'h0, "R11 set wins");
    step(0, 8'h00, 8'h00, 0, 4'h0, 0, 4'h9, "R8");
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule